// File: doc/BRIEF.md
# Character Bank Address Generator

This block turns a pattern-table fetch address from the picture processor into a physical character-memory address. It holds twelve bank registers, a two-bit bank-size mode and a two-bit upper-bank value, all written through a narrow CPU register port. Eight registers serve the first register set (set A), selected with `setB` low. The other four serve the second set (set B), selected with `setB` high. The `setB` input stands in for the fetch-phase choice between the sprite and background register sets.

The mode sets the bank granularity: 8 KiB, 4 KiB, 2 KiB or 1 KiB. The register that supplies the bank number comes from pattern-address bits 12:10, with low index bits forced to one as the bank size grows. The upper-bank value is copied into bits 9:8 of a bank register when that register is written. The copy is not looked up live at fetch time. The address is cut to the size of the character memory.

Any write that changes the banking state does two further things. It drives a one-cycle pulse that cancels the extended-tile and split-region bank overrides kept elsewhere. A bank write also records whether set A or set B was written last.

Top module: `chr_bank_gen`

## Requirements
- R1: After reset, every bank register, the mode and the upper value are zero. `lastSetB` and `ovrClear` are low, so `chrAddr` equals `patAddr` truncated to the memory width.
- R2: A write to offset 0x01 stores `wrData[1:0]` as the mode (0 = 8 KiB, 1 = 4 KiB, 2 = 2 KiB, 3 = 1 KiB) and raises `ovrClear` in the next cycle.
- R3: A write to offset 0x20+n (n = 0..7) loads bank register n with {upper value, `wrData`}. In the next cycle `lastSetB` is low and `ovrClear` is high.
- R4: A write to offset 0x28+m (m = 0..3) loads bank register 8+m the same way. In the next cycle `lastSetB` is high and `ovrClear` is high.
- R5: A write to offset 0x30 stores `wrData[1:0]` as the upper value and raises `ovrClear` in the next cycle. It changes no bank register that is already written; only later bank writes take it in.
- R6: In mode 0, set A uses register 7 and set B uses register 11. The address is (register bits 7:0) × 8192 + `patAddr[12:0]`.
- R7: In mode 1 the register index is the slot OR 3. The address is (register bits 7:0) × 4096 + `patAddr[11:0]`. The slot is `patAddr[12:10]` for set A and 8 + `patAddr[11:10]` for set B.
- R8: In mode 2 the register index is the slot OR 1. The address is (full 10-bit register) × 2048 + `patAddr[10:0]`.
- R9: In mode 3 the register index is the slot itself. The address is (full register) × 1024 + `patAddr[9:0]`.
- R10: `chrAddr` is the computed address modulo 2^`CHR_ADDR_W`.
- R11: A write to any other offset changes no state. `ovrClear` stays low and `lastSetB` keeps its value. With no write, `ovrClear` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 6 | Register offset |
| wrData | input | 8 | Register write data |
| patAddr | input | 13 | Pattern-table fetch address |
| setB | input | 1 | Selects register set B for the current fetch |
| chrAddr | output | CHR_ADDR_W (18) | Character memory address |
| lastSetB | output | 1 | High when the most recent bank write went to set B |
| ovrClear | output | 1 | One-cycle pulse that cancels the extended and split bank overrides |

## Verification
The bench uses the default parameters: 8-bit data, 2-bit upper value and an 18-bit (256 KiB) character memory. With these values a 1 KiB or 2 KiB bank of 0x3FF produces a 20- or 21-bit address, so the masking of R10 truncates real bits. The 8 KiB mode with a full 8-bit bank also exceeds the memory and wraps. The bench sweeps every slot in each mode for both sets and writes the upper value between bank writes. It then compares each address against a behavioural model, which exposes stale or live use of the upper bits and a wrong OR rule.

// File: rtl/chr_bank_pkg.sv
package chr_bank_pkg;
  localparam int REG_OFS_W   = 6;
  localparam int NUM_BANKS   = 12;
  localparam int SET_A_COUNT = 8;
  localparam int BANK_SEL_W  = $clog2(NUM_BANKS);

  localparam logic [REG_OFS_W-1:0] MODE_OFS  = 6'h01;
  localparam logic [REG_OFS_W-1:0] BANK_BASE = 6'h20;
  localparam logic [REG_OFS_W-1:0] UPPER_OFS = 6'h30;

  typedef enum logic [1:0] {
    CHR_8K = 2'd0,
    CHR_4K = 2'd1,
    CHR_2K = 2'd2,
    CHR_1K = 2'd3
  } chrMode_t;

  typedef struct packed {
    logic                  bankWe;
    logic [BANK_SEL_W-1:0] bankSel;
    logic                  modeWe;
    logic                  upperWe;
  } chrStrobes_t;
endpackage

// File: rtl/chr_bank_ctrl.sv
module chr_bank_ctrl
  import chr_bank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wrEn,
  input  logic [REG_OFS_W-1:0] wrAddr,
  output chrStrobes_t          strobes,
  output logic                 lastSetB,
  output logic                 ovrClear
);
  logic [REG_OFS_W-1:0] relOfs;
  logic                 inBankWindow;

  assign relOfs       = wrAddr - BANK_BASE;
  assign inBankWindow = (wrAddr >= BANK_BASE) &&
                        (wrAddr < BANK_BASE + REG_OFS_W'(NUM_BANKS));

  always_comb begin
    strobes = '0;
    if (wrEn) begin
      if (wrAddr == MODE_OFS) begin
        strobes.modeWe = 1'b1;
      end else if (wrAddr == UPPER_OFS) begin
        strobes.upperWe = 1'b1;
      end else if (inBankWindow) begin
        strobes.bankWe  = 1'b1;
        strobes.bankSel = relOfs[BANK_SEL_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lastSetB <= 1'b0;
      ovrClear <= 1'b0;
    end else begin
      ovrClear <= strobes.bankWe | strobes.modeWe | strobes.upperWe;
      if (strobes.bankWe) begin
        lastSetB <= (strobes.bankSel >= BANK_SEL_W'(SET_A_COUNT));
      end
    end
  end
endmodule

// File: rtl/chr_bank_datapath.sv
module chr_bank_datapath
  import chr_bank_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int UPPER_W    = 2,
  parameter int PAT_W      = 13,
  parameter int CHR_ADDR_W = 18
) (
  input  logic                  clk,
  input  logic                  rst,
  input  chrStrobes_t           strobes,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [PAT_W-1:0]      patAddr,
  input  logic                  setB,
  output logic [CHR_ADDR_W-1:0] chrAddr
);
  localparam int BANK_W  = DATA_W + UPPER_W;
  localparam int WIDE_8K = DATA_W + 13;
  localparam int WIDE_2K = BANK_W + 11;
  localparam int FULL_W  = (WIDE_8K > WIDE_2K) ? WIDE_8K : WIDE_2K;

  logic [BANK_W-1:0]     bankReg [NUM_BANKS];
  chrMode_t              mode;
  logic [UPPER_W-1:0]    upper;
  logic [BANK_SEL_W-1:0] slot;
  logic [BANK_SEL_W-1:0] pickIdx;
  logic [BANK_W-1:0]     pickBank;
  logic [FULL_W-1:0]     fullAddr;

  for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        bankReg[gi] <= '0;
      end else if (strobes.bankWe && strobes.bankSel == BANK_SEL_W'(gi)) begin
        bankReg[gi] <= {upper, wrData};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= CHR_8K;
      upper <= '0;
    end else begin
      if (strobes.modeWe)  mode  <= chrMode_t'(wrData[1:0]);
      if (strobes.upperWe) upper <= wrData[UPPER_W-1:0];
    end
  end

  assign slot = setB ? {2'b10, patAddr[11:10]} : {1'b0, patAddr[12:10]};

  always_comb begin
    unique case (mode)
      CHR_8K:  pickIdx = setB ? BANK_SEL_W'(11) : BANK_SEL_W'(7);
      CHR_4K:  pickIdx = slot | BANK_SEL_W'(3);
      CHR_2K:  pickIdx = slot | BANK_SEL_W'(1);
      default: pickIdx = slot;
    endcase
  end

  assign pickBank = bankReg[pickIdx];

  always_comb begin
    unique case (mode)
      CHR_8K:  fullAddr = FULL_W'({pickBank[DATA_W-1:0], patAddr[12:0]});
      CHR_4K:  fullAddr = FULL_W'({pickBank[DATA_W-1:0], patAddr[11:0]});
      CHR_2K:  fullAddr = FULL_W'({pickBank, patAddr[10:0]});
      default: fullAddr = FULL_W'({pickBank, patAddr[9:0]});
    endcase
  end

  assign chrAddr = fullAddr[CHR_ADDR_W-1:0];
endmodule

// File: rtl/chr_bank_gen.sv
module chr_bank_gen
  import chr_bank_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int UPPER_W    = 2,
  parameter int PAT_W      = 13,
  parameter int CHR_ADDR_W = 18
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wrEn,
  input  logic [REG_OFS_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [PAT_W-1:0]      patAddr,
  input  logic                  setB,
  output logic [CHR_ADDR_W-1:0] chrAddr,
  output logic                  lastSetB,
  output logic                  ovrClear
);
  chrStrobes_t strobes;

  chr_bank_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr),
    .strobes(strobes), .lastSetB(lastSetB), .ovrClear(ovrClear)
  );

  chr_bank_datapath #(
    .DATA_W(DATA_W), .UPPER_W(UPPER_W), .PAT_W(PAT_W), .CHR_ADDR_W(CHR_ADDR_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .wrData(wrData),
    .patAddr(patAddr), .setB(setB), .chrAddr(chrAddr)
  );
endmodule

// File: rtl/chr_bank_gen_chk.sv
module chr_bank_gen_chk
  import chr_bank_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 wrEn,
  input logic [REG_OFS_W-1:0] wrAddr,
  input logic                 lastSetB,
  input logic                 ovrClear
);
  logic isSetA, isSetB, isKnown;
  assign isSetA  = wrEn && wrAddr >= 6'h20 && wrAddr <= 6'h27;
  assign isSetB  = wrEn && wrAddr >= 6'h28 && wrAddr <= 6'h2B;
  assign isKnown = wrAddr == 6'h01 || wrAddr == 6'h30 ||
                   (wrAddr >= 6'h20 && wrAddr <= 6'h2B);

  // R1: outputs start from their cleared values once reset lifts
  a_r1_reset_state: assert property (@(posedge clk)
    $fell(rst) |-> (!lastSetB && !ovrClear));

  // R2: a mode write cancels the overrides
  a_r2_mode_clear: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == 6'h01) |=> ovrClear);

  // R3: a set A write records set A and cancels the overrides
  a_r3_set_a: assert property (@(posedge clk) disable iff (rst)
    isSetA |=> (!lastSetB && ovrClear));

  // R4: a set B write records set B and cancels the overrides
  a_r4_set_b: assert property (@(posedge clk) disable iff (rst)
    isSetB |=> (lastSetB && ovrClear));

  // R5: an upper-value write cancels the overrides, set record kept
  a_r5_upper_clear: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == 6'h30) |=> (ovrClear && $stable(lastSetB)));

  // R11: idle cycles or unknown offsets leave the record and give no pulse
  a_r11_no_effect: assert property (@(posedge clk) disable iff (rst)
    (!wrEn || !isKnown) |=> (!ovrClear && $stable(lastSetB)));
endmodule

bind chr_bank_gen chr_bank_gen_chk u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr),
  .lastSetB(lastSetB), .ovrClear(ovrClear)
);

// File: tb/chr_bank_gen_bench.sv
module chr_bank_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CHR_AW     = 18;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wrEn = 1'b0;
  logic [5:0]        wrAddr = '0;
  logic [7:0]        wrData = '0;
  logic [12:0]       patAddr = '0;
  logic              setB = 1'b0;
  logic [CHR_AW-1:0] chrAddr;
  logic              lastSetB;
  logic              ovrClear;

  int checks = 0;
  int failures = 0;

  int bankM [12];
  int modeM = 0, upperM = 0, lastBM = 0, clrM = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chr_bank_gen #(.CHR_ADDR_W(CHR_AW)) u_chr_bank_gen (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .patAddr(patAddr), .setB(setB), .chrAddr(chrAddr),
    .lastSetB(lastSetB), .ovrClear(ovrClear)
  );

  function automatic int expAddr(int pa, int sb);
    int slot, r, a;
    slot = sb ? 8 + ((pa >> 10) & 3) : ((pa >> 10) & 7);
    case (modeM)
      0: begin r = sb ? 11 : 7; a = (bankM[r] & 255) * 8192 + (pa & 8191); end
      1: begin r = slot | 3;    a = (bankM[r] & 255) * 4096 + (pa & 4095); end
      2: begin r = slot | 1;    a = bankM[r] * 2048 + (pa & 2047); end
      default: begin r = slot;  a = bankM[r] * 1024 + (pa & 1023); end
    endcase
    return a % (1 << CHR_AW);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    check(tag, "chrAddr", int'(chrAddr), expAddr(int'(patAddr), int'(setB)));
    check(tag, "lastSetB", int'(lastSetB), lastBM);
    check(tag, "ovrClear", int'(ovrClear), clrM);
  endtask

  // drive one cycle, update the model at the edge, compare at the falling edge
  task automatic step(string tag, bit wr, int a, int d, int pa, bit sb);
    wrEn = wr; wrAddr = 6'(a); wrData = 8'(d); patAddr = 13'(pa); setB = sb;
    @(posedge clk);
    clrM = 0;
    if (wr) begin
      if (a == 1) begin modeM = d & 3; clrM = 1; end
      else if (a == 48) begin upperM = d & 3; clrM = 1; end
      else if (a >= 32 && a < 44) begin
        bankM[a - 32] = (d & 255) + upperM * 256;
        lastBM = (a >= 40) ? 1 : 0;
        clrM = 1;
      end
    end
    @(negedge clk);
    wrEn = 1'b0;
    compareAll(tag);
  endtask

  task automatic sweep(string tag);
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 8; k++)
        step(tag, 0, 0, 0, k * 1024 + 13'h155 + k * 37, s[0]);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 12; i++) bankM[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: cleared state, address equals pattern address
    patAddr = 13'h1ABC; #1; compareAll("R1");
    step("R1", 0, 0, 0, 13'h0765, 1);

    // R3: set A loads; R4: set B loads
    for (int i = 0; i < 8; i++) step("R3", 1, 32 + i, 8'h11 * (i + 1), 0, 0);
    for (int i = 0; i < 4; i++) step("R4", 1, 40 + i, 8'hA1 + i * 16, 0, 1);
    step("R3", 1, 36, 8'h5C, 13'h0400, 0);

    // R5: upper value captured only by later writes
    step("R5", 1, 48, 8'hFF, 0, 0);
    step("R11", 0, 0, 0, 0, 0);
    step("R5", 1, 34, 8'h55, 0, 0);
    step("R5", 1, 43, 8'hFF, 0, 1);
    step("R5", 1, 48, 8'h01, 0, 0);
    step("R5", 1, 35, 8'hFF, 0, 0);

    // R6..R9: every mode, both sets, all slots
    sweep("R6");
    step("R2", 1, 1, 8'hFD, 0, 0);
    sweep("R7");
    step("R2", 1, 1, 8'h02, 0, 0);
    sweep("R8");
    step("R2", 1, 1, 8'h03, 0, 1);
    sweep("R9");

    // R10: large banks wrap at the memory size
    step("R10", 1, 48, 8'h03, 0, 0);
    step("R10", 1, 38, 8'hFF, 0, 0);
    step("R10", 0, 0, 0, 13'h1BFF, 0);
    step("R2", 1, 1, 8'h02, 0, 0);
    step("R10", 0, 0, 0, 13'h1FFF, 0);
    step("R2", 1, 1, 8'h00, 0, 0);
    step("R10", 0, 0, 0, 13'h1FFF, 0);

    // R11: unknown offsets touch nothing
    step("R4", 1, 41, 8'h3C, 0, 1);
    step("R11", 1, 0, 8'hFF, 0, 0);
    step("R11", 1, 44, 8'hFF, 0, 0);
    step("R11", 1, 49, 8'h02, 0, 0);
    step("R11", 1, 31, 8'h02, 0, 0);
    step("R11", 1, 2, 8'h02, 0, 0);
    step("R11", 1, 63, 8'h02, 0, 0);
    step("R2", 1, 1, 8'h03, 0, 0);
    sweep("R11");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule